// File: doc/BRIEF.md
# Register-Transfer Accumulator Processor

This block is a minimal single-accumulator processor. It holds a word-addressed internal store, a program counter, a memory address register, a memory data register, an instruction register and an accumulator. Each instruction is a fixed chain of register transfers, and every transfer takes one clock period. Nothing overlaps and nothing is pipelined. The instruction set has three cases: LOAD copies a store word into the accumulator, opcode zero stops the machine, and every other opcode is a no-op.

A testbench fills the store through a write port before it releases reset. The write port also works while the machine runs, and a write lands at the next clock edge. The accumulator and a halted flag are the only outputs. Both come straight from registers.

Register bits are numbered from 0 at the most significant position. The opcode therefore sits in the top six bits of a word, and the operand address sits in the bottom ten.

Top module: `rt_acc_cpu`

## Requirements
- R1: A clock edge with `rst` high clears the accumulator and the halted flag. The first instruction after reset is fetched from address 0.
- R2: Every instruction begins with four one-cycle fetch transfers in this order: address register takes PC, data register takes the store word, instruction register takes the data register, PC steps.
- R3: LOAD (opcode 1) lasts seven cycles, fetch included. The accumulator takes the addressed store word on the seventh clock edge of the instruction and keeps its value on the other six.
- R4: The opcode is instruction bits 0..5 (the six most significant bits). The operand address is bits 22..31 (the ten least significant bits). The contents of bits 6..21 have no effect.
- R5: Opcode 0 raises `halted` on the fourth edge of that instruction and not earlier. From then on `halted` stays high and the accumulator stays fixed until reset.
- R6: PC advances by exactly one per instruction through its own incrementer, and it wraps from 1023 to 0.
- R7: With `pre_we` high, the store word at `pre_addr` takes `pre_data` at the clock edge. This holds during reset and while the machine runs.
- R8: Any opcode other than 0 or 1 lasts four cycles, leaves the accumulator unchanged and goes on to the next fetch.
- R9: LOAD can read any address, including 1023 and the address of the LOAD word itself. In that last case the accumulator receives the instruction's own encoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all transfers happen on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pre_we | input | 1 | Store write enable for preloading |
| pre_addr | input | 10 | Store word address for a preload write |
| pre_data | input | 32 | Word to write; bit 0 is the MSB |
| acc_out | output | 32 | Accumulator contents |
| halted | output | 1 | High once a halt instruction has completed |

## Verification
The bench checks exact cycle positions. The accumulator must not change on the sixth edge of a LOAD and must change on the seventh. A no-op must cost four cycles, so a sequencer that skipped or added a decode state would shift every later timestamp. It checks a LOAD whose operand field is surrounded by set junk bits, a LOAD of address 1023, and a LOAD of its own address. A wrong field slice or a read taken from the wrong register would give the wrong value in those cases. A run through all 1024 addresses, with a halt written into the store mid-run, catches a PC that fails to wrap or a store write that is ignored while the machine runs.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef enum logic [2:0] {
    S_FMA  = 3'd0,
    S_FMD  = 3'd1,
    S_FIR  = 3'd2,
    S_FPC  = 3'd3,
    S_XMA  = 3'd4,
    S_XMD  = 3'd5,
    S_XAC  = 3'd6,
    S_HALT = 3'd7
  } st_t;

  localparam int unsigned OPW = 6;
  localparam logic [0:OPW-1] OP_HALT = 6'd0;
  localparam logic [0:OPW-1] OP_LOAD = 6'd1;

endpackage

// File: rtl/rtc_mem.sv
module rtc_mem #(
  parameter int unsigned AW = 10,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [0:AW-1] waddr,
  input  logic [0:DW-1] wdata,
  input  logic          re,
  input  logic [0:AW-1] raddr,
  output logic [0:DW-1] rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [0:DW-1] store [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  // registered, enabled read port: this register is the data register
  always_ff @(posedge clk) begin
    if (re) rdata <= store[raddr];
  end

endmodule

// File: rtl/rtc_inc.sv
module rtc_inc #(
  parameter int unsigned W = 10
) (
  input  logic [0:W-1] a,
  output logic [0:W-1] y
);
  // ripple increment: each bit flips when all less significant bits are one
  logic [0:W] carry;
  assign carry[W] = 1'b1;
  for (genvar i = W - 1; i >= 0; i--) begin : g_bit
    assign y[i]     = a[i] ^ carry[i+1];
    assign carry[i] = a[i] & carry[i+1];
  end
endmodule

// File: rtl/rtc_seq.sv
module rtc_seq
  import rtc_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic [0:OPW-1] op,
  output st_t           st,
  output logic          halted
);
  st_t st_nx;

  always_comb begin
    st_nx = st;
    unique case (st)
      S_FMA:  st_nx = S_FMD;
      S_FMD:  st_nx = S_FIR;
      S_FIR:  st_nx = S_FPC;
      S_FPC: begin
        if (op == OP_LOAD)      st_nx = S_XMA;
        else if (op == OP_HALT) st_nx = S_HALT;
        else                    st_nx = S_FMA;
      end
      S_XMA:  st_nx = S_XMD;
      S_XMD:  st_nx = S_XAC;
      S_XAC:  st_nx = S_FMA;
      S_HALT: st_nx = S_HALT;
      default: st_nx = S_FMA;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_FMA;
      halted <= 1'b0;
    end else begin
      st <= st_nx;
      if (st == S_FPC && op == OP_HALT) halted <= 1'b1;
    end
  end
endmodule

// File: rtl/rt_acc_cpu.sv
module rt_acc_cpu
  import rtc_pkg::*;
#(
  parameter int unsigned AW = 10,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pre_we,
  input  logic [0:AW-1] pre_addr,
  input  logic [0:DW-1] pre_data,
  output logic [0:DW-1] acc_out,
  output logic          halted
);
  localparam int unsigned ADR_LO = DW - AW;

  st_t           st;
  logic [0:AW-1] pc, ma, pc_inc;
  logic [0:DW-1] md, ir, ac;
  logic          rd_en;
  logic          unused_mid;

  assign unused_mid = ^ir[OPW:ADR_LO-1];
  assign rd_en      = (st == S_FMD) || (st == S_XMD);

  rtc_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk   (clk),
    .we    (pre_we),
    .waddr (pre_addr),
    .wdata (pre_data),
    .re    (rd_en),
    .raddr (ma),
    .rdata (md)
  );

  rtc_inc #(.W(AW)) u_inc (
    .a (pc),
    .y (pc_inc)
  );

  rtc_seq u_seq (
    .clk    (clk),
    .rst    (rst),
    .op     (ir[0:OPW-1]),
    .st     (st),
    .halted (halted)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= '0;
      ma <= '0;
      ir <= '0;
      ac <= '0;
    end else begin
      unique case (st)
        S_FMA:   ma <= pc;
        S_FIR:   ir <= md;
        S_FPC:   pc <= pc_inc;
        S_XMA:   ma <= ir[ADR_LO:DW-1];
        S_XAC:   ac <= md;
        default: ;
      endcase
    end
  end

  assign acc_out = ac;

endmodule

// File: rtl/rtc_chk.sv
module rtc_chk
  import rtc_pkg::*;
#(
  parameter int unsigned AW = 10,
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst,
  input st_t           st,
  input logic [0:AW-1] pc,
  input logic [0:DW-1] acc,
  input logic          halted
);
  // R2
  fetch_a_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_FMA) |=> (st == S_FMD));
  // R2
  fetch_b_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_FMD) |=> (st == S_FIR));
  // R2
  fetch_c_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_FIR) |=> (st == S_FPC));
  // R6
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_FPC) |=> (pc == AW'($past(pc) + 1'b1)));
  // R6
  pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st != S_FPC) |=> $stable(pc));
  // R3
  acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st != S_XAC) |=> $stable(acc));
  // R5
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && $stable(acc)));
  // R5
  halt_state_chk: assert property (@(posedge clk) disable iff (rst)
    halted |-> (st == S_HALT));
endmodule

bind rt_acc_cpu rtc_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .st     (st),
  .pc     (pc),
  .acc    (acc_out),
  .halted (halted)
);

// File: tb/rt_acc_cpu_bench.sv
module rt_acc_cpu_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pre_we = 1'b0;
  logic [9:0]  pre_addr = '0;
  logic [31:0] pre_data = '0;
  logic [31:0] acc_out;
  logic        halted;

  int checks = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rt_acc_cpu u_rt_acc_cpu (
    .clk(clk), .rst(rst), .pre_we(pre_we), .pre_addr(pre_addr),
    .pre_data(pre_data), .acc_out(acc_out), .halted(halted)
  );

  // behavioural reference: instruction-level timing from the requirements
  logic [31:0] bmem [0:1023];
  int          m_pc, m_cnt, m_len;
  logic [31:0] m_ins, m_ac;
  bit          m_h;

  always @(posedge clk) begin
    if (rst) begin
      m_pc = 0; m_ac = '0; m_h = 1'b0; m_cnt = 0; cyc = 0;
    end else begin
      cyc = cyc + 1;
      if (!m_h) begin
        m_cnt = m_cnt + 1;
        if (m_cnt == 1) begin
          m_ins = bmem[m_pc];
          m_len = (m_ins[31:26] == 6'd1) ? 7 : 4;
        end
        if (m_cnt == 4) begin
          m_pc = (m_pc + 1) % 1024;
          if (m_ins[31:26] == 6'd0) m_h = 1'b1;
        end
        if (m_ins[31:26] == 6'd1 && m_cnt == 7) m_ac = bmem[m_ins[9:0]];
        if (m_cnt == m_len) m_cnt = 0;
      end
    end
    if (pre_we) bmem[pre_addr] = pre_data;
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (acc_out !== m_ac) begin
        bad++;
        $display("FAIL R3 cycle %0d acc actual=%h expected=%h", cyc, acc_out, m_ac);
      end
      checks++;
      if (halted !== m_h) begin
        bad++;
        $display("FAIL R5 cycle %0d halted actual=%b expected=%b", cyc, halted, m_h);
      end
    end
  end

  function automatic logic [31:0] mk(input int op, input int adr, input int junk);
    return {op[5:0], junk[15:0], adr[9:0]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s cycle %0d actual=%h expected=%h", req, cyc, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    pre_we = 1'b1; pre_addr = a[9:0]; pre_data = d;
    @(negedge clk);
    pre_we = 1'b0;
  endtask

  task automatic at(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic fill_nop;
    for (int i = 0; i < 1024; i++) wr(i, mk(2, 0, 0));
  endtask

  initial begin
    // run 1: LOAD, no-op, junk-field LOAD of 1023, self LOAD, halt
    rst = 1'b1;
    fill_nop();
    wr(0, mk(1, 100, 0));
    wr(1, mk(7, 0, 0));
    wr(2, mk(1, 1023, 16'hA5C3));
    wr(3, mk(1, 3, 0));
    wr(4, mk(0, 0, 16'h1234));
    wr(100, 32'hDEADBEEF);
    wr(1023, 32'h12345678);
    @(negedge clk);
    chk("R1 acc", acc_out, 32'h0);
    chk("R1 halted", {31'b0, halted}, 32'h0);
    rst = 1'b0;
    at(6);  chk("R3 before 7th edge", acc_out, 32'h0);
    at(7);  chk("R3 7th edge", acc_out, 32'hDEADBEEF);
    at(11); chk("R8 no-op", acc_out, 32'hDEADBEEF);
    at(17); chk("R4 before", acc_out, 32'hDEADBEEF);
    at(18); chk("R4 R9 addr 1023 junk bits", acc_out, 32'h12345678);
    at(24); chk("R3 hold", acc_out, 32'h12345678);
    at(25); chk("R9 self load", acc_out, mk(1, 3, 0));
    at(28); chk("R5 not yet", {31'b0, halted}, 32'h0);
    at(29); chk("R5 halt at 4th edge", {31'b0, halted}, 32'h1);
    at(50); chk("R5 sticky", {31'b0, halted}, 32'h1);
    chk("R5 acc frozen", acc_out, mk(1, 3, 0));

    // run 2: walk every address, PC wrap, halt written while running
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R1 re-reset acc", acc_out, 32'h0);
    chk("R1 re-reset halted", {31'b0, halted}, 32'h0);
    fill_nop();
    wr(0, mk(1, 6, 0));
    wr(5, 32'hFC000055);
    wr(6, 32'hF8000066);
    wr(1022, mk(1, 5, 0));
    @(negedge clk);
    rst = 1'b0;
    at(7);    chk("R1 start at 0", acc_out, 32'hF8000066);
    at(100);  wr(1, mk(0, 0, 0));
    at(4097); chk("R6 before top", acc_out, 32'hF8000066);
    at(4098); chk("R6 addr 1022 reached", acc_out, 32'hFC000055);
    at(4109); chk("R6 wrap to 0", acc_out, 32'hF8000066);
    at(4112); chk("R7 R2 not yet halted", {31'b0, halted}, 32'h0);
    at(4113); chk("R7 live write halts", {31'b0, halted}, 32'h1);
    at(4120);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (40000) @(posedge clk);
    bad++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule